// File: doc/BRIEF.md
# Flexible Payload Field Extractor

This block watches a byte-wide packet stream and lifts a two-byte field out of each packet for a downstream flow classifier. The position of the field is measured from the first byte of the Ethernet MAC header, which is the first byte of the packet. A packet chooses one of 64 configuration entries through a select input sampled with its first beat. Each entry holds the field position in 16-bit word units and a flag that says whether the field takes part in matching.

Entries are written through a configuration request port that takes byte positions and a 16-bit match mask. The block checks each request: the first byte position must be even and no larger than 62, the second byte must be the first plus one, and the mask must be all ones or all zeros. An accepted request is packed into an 8-bit slot. Four slots share each 32-bit configuration word, with entry i held in word i/4 at slot i%4. A refused request changes nothing and raises a sticky error flag.

The extracted value puts the first byte in its upper half and the second byte in its lower half. A one-cycle strobe marks a new value. If a packet ends before both bytes have arrived, no value is produced and a one-cycle short-packet flag is raised instead.

Top module: `flx_field_extract`

## Requirements
- R1: After reset every entry selects byte positions 12 and 13 with matching disabled, and fld_valid, fld_match, short_pkt, cfg_err and fld_data are all zero.
- R2: For an entry with word offset W, fld_data becomes {byte 2W, byte 2W+1}, with the byte on the start-of-packet beat counted as byte 0.
- R3: fld_valid is high for exactly one cycle, the cycle after the beat that carries byte 2W+1, and at most once per packet.
- R4: The entry is chosen by in_sel on the start-of-packet beat. Entries that share a 32-bit configuration word (entry i in word i/4, slot i%4) are written independently of each other.
- R5: A configuration request whose first byte position is odd is refused.
- R6: A configuration request whose second byte position is not the first position plus one is refused.
- R7: A first byte position above 62 is refused. Position 62 is accepted and extracts bytes 62 and 63.
- R8: A mask of 16'hFFFF sets fld_match to 1 for that entry. A mask of 16'h0000 sets it to 0. Any other mask is refused.
- R9: A refused request leaves the stored entry unchanged and sets cfg_err the cycle after the request. cfg_err stays high until reset.
- R10: When the end-of-packet beat arrives before byte 2W+1, fld_valid stays low and short_pkt is high for one cycle after that beat.
- R11: Cycles with in_valid low neither advance the byte count nor produce any output event.
- R12: A configuration write made while a packet is in progress does not affect that packet. The entry is captured on the start-of-packet beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration request strobe |
| cfg_entry | input | 6 | Entry to write |
| cfg_first | input | 8 | Byte position of the first field byte |
| cfg_second | input | 8 | Byte position of the second field byte |
| cfg_mask | input | 16 | Match mask, all ones or all zeros |
| in_valid | input | 1 | Stream beat valid |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_data | input | 8 | Stream byte |
| in_sel | input | 6 | Entry select, sampled with in_sop |
| fld_data | output | 16 | Extracted field, first byte in the upper half |
| fld_valid | output | 1 | One-cycle strobe for a new field |
| fld_match | output | 1 | Field takes part in matching |
| short_pkt | output | 1 | One-cycle flag: the packet ended before the field |
| cfg_err | output | 1 | Sticky flag for a refused configuration request |

## Verification
The bench runs the extraction on several kinds of packets. Packets long enough to hold the field check byte order and the exact strobe cycle. Packets that end one byte early, or on a single beat, separate a correct short-packet flag from an off-by-one position. Packets with idle gaps would expose a byte count that moves on idle cycles. The configuration side is tried with even and odd positions, non-adjacent second bytes, positions on both sides of 62, and all-ones, all-zeros and partial masks, interleaved with packets so that a refused write which still changed the entry shows up in the extracted bytes. A write made in the middle of a packet shows whether the entry is latched at start of packet. Several hundred random packets, with random configuration traffic and entries drawn from all 64, are compared against a bench model.

// File: rtl/flx_pkg.sv
package flx_pkg;

  localparam int SLOT_W = 8;
  localparam int OFF_W  = 7;
  localparam int POS_W  = OFF_W + 1;

  // One configuration slot: matching disable flag plus word offset.
  typedef struct packed {
    logic             mask_off;
    logic [OFF_W-1:0] woff;
  } flx_slot_t;

  // Rules for accepting a configuration request.
  function automatic logic flx_rules_ok(input logic [7:0]  first_b,
                                        input logic [7:0]  second_b,
                                        input logic [15:0] mask,
                                        input int unsigned max_off);
    logic [8:0] next_b;
    logic       aligned;
    logic       adjacent;
    logic       in_range;
    logic       mask_ok;
    next_b   = {1'b0, first_b} + 9'd1;
    aligned  = ~first_b[0];
    adjacent = ({1'b0, second_b} == next_b);
    in_range = (32'(first_b) <= max_off);
    mask_ok  = (mask == 16'h0000) || (mask == 16'hFFFF);
    return aligned & adjacent & in_range & mask_ok;
  endfunction

  // Pack an accepted request into a slot.
  function automatic flx_slot_t flx_encode(input logic [7:0]  first_b,
                                           input logic [15:0] mask);
    flx_slot_t s;
    s.mask_off = (mask != 16'hFFFF);
    s.woff     = first_b[7:1];
    return s;
  endfunction

  // Byte positions of the upper and lower field bytes.
  function automatic logic [POS_W-1:0] flx_hi_pos(input flx_slot_t s);
    return {s.woff, 1'b0};
  endfunction

  function automatic logic [POS_W-1:0] flx_lo_pos(input flx_slot_t s);
    return {s.woff, 1'b1};
  endfunction

endpackage

// File: rtl/flx_cfg_check.sv
module flx_cfg_check
  import flx_pkg::*;
#(
  parameter int MAX_BYTE_OFF = 62
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [7:0]      first_b,
  input  logic [7:0]      second_b,
  input  logic [15:0]     mask,
  output logic            accept,
  output logic            reject,
  output flx_slot_t       slot,
  output logic            err_q
);

  logic rules_pass;

  always_comb begin
    rules_pass = flx_rules_ok(first_b, second_b, mask, MAX_BYTE_OFF);
    accept     = req & rules_pass;
    reject     = req & ~rules_pass;
    slot       = flx_encode(first_b, mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (reject) begin
      err_q <= 1'b1;
    end
  end

  // R9: error flag is sticky
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R9: a refused request raises the flag on the next cycle
  assert_reject_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> err_q);

endmodule

// File: rtl/flx_slot_store.sv
module flx_slot_store
  import flx_pkg::*;
#(
  parameter int ENTRIES        = 64,
  parameter int SLOTS_PER_WORD = 4,
  parameter int RESET_BYTE_OFF = 12,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int SEL_W  = $clog2(SLOTS_PER_WORD),
  localparam int WORDS  = ENTRIES / SLOTS_PER_WORD,
  localparam int WORD_W = SLOTS_PER_WORD * SLOT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  flx_slot_t               wr_slot,
  input  logic [IDX_W-1:0]        rd_idx,
  output flx_slot_t               rd_slot,
  output logic [WORDS*WORD_W-1:0] words_flat
);

  localparam flx_slot_t RST_SLOT = '{mask_off: 1'b1,
                                     woff: OFF_W'(RESET_BYTE_OFF / 2)};

  logic [IDX_W-SEL_W-1:0] wr_word;
  logic [SEL_W-1:0]       wr_lane;

  assign wr_word = wr_idx[IDX_W-1:SEL_W];
  assign wr_lane = wr_idx[SEL_W-1:0];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              hit;

    assign hit = wr_en && (wr_word == (IDX_W-SEL_W)'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q <= {SLOTS_PER_WORD{RST_SLOT}};
      end else if (hit) begin
        word_q[wr_lane*SLOT_W +: SLOT_W] <= wr_slot;
      end
    end

    assign words_flat[g*WORD_W +: WORD_W] = word_q;
  end

  // Entry i sits at word i/SLOTS_PER_WORD, lane i%SLOTS_PER_WORD, so its
  // flat bit position is i*SLOT_W.
  assign rd_slot = words_flat[int'(rd_idx)*SLOT_W +: SLOT_W];

endmodule

// File: rtl/flx_field_capture.sv
module flx_field_capture
  import flx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sop,
  input  logic        in_eop,
  input  logic [7:0]  in_data,
  input  flx_slot_t   sop_slot,
  output logic [15:0] fld_data,
  output logic        fld_valid,
  output logic        fld_match,
  output logic        short_pkt
);

  logic             in_pkt_q;
  flx_slot_t        slot_q;
  logic [POS_W-1:0] pos_q;
  logic             done_q;
  logic [7:0]       hi_q;

  logic             beat;
  flx_slot_t        cur_slot;
  logic [POS_W-1:0] cur_pos;
  logic             done_cur;
  logic             take_hi;
  logic             take_lo;
  logic             pkt_end;

  always_comb begin
    beat     = in_valid & (in_sop | in_pkt_q);
    cur_slot = in_sop ? sop_slot : slot_q;
    cur_pos  = in_sop ? '0 : pos_q;
    done_cur = in_sop ? 1'b0 : done_q;
    take_hi  = beat && (cur_pos == flx_hi_pos(cur_slot));
    take_lo  = beat && (cur_pos == flx_lo_pos(cur_slot));
    pkt_end  = beat & in_eop;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt_q  <= 1'b0;
      slot_q    <= '0;
      pos_q     <= '0;
      done_q    <= 1'b0;
      hi_q      <= '0;
      fld_data  <= '0;
      fld_valid <= 1'b0;
      fld_match <= 1'b0;
      short_pkt <= 1'b0;
    end else begin
      fld_valid <= take_lo;
      short_pkt <= pkt_end & ~(done_cur | take_lo);
      if (beat) begin
        pos_q    <= (&cur_pos) ? cur_pos : cur_pos + POS_W'(1);
        done_q   <= done_cur | take_lo;
        in_pkt_q <= ~in_eop;
        if (in_sop) begin
          slot_q <= sop_slot;
        end
      end
      if (take_hi) begin
        hi_q <= in_data;
      end
      if (take_lo) begin
        fld_data  <= {hi_q, in_data};
        fld_match <= ~cur_slot.mask_off;
      end
    end
  end

  // R3: the strobe never lasts two cycles
  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fld_valid |=> !fld_valid);

  // R10: a short-packet flag only follows an end-of-packet beat
  assert_short_after_eop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    short_pkt |-> $past(in_valid && in_eop));

  // R10: field strobe and short flag never coincide
  assert_valid_short_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fld_valid && short_pkt));

  // R11: an idle cycle leaves the byte count alone
  assert_idle_holds_pos_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(pos_q));

endmodule

// File: rtl/flx_field_extract.sv
module flx_field_extract
  import flx_pkg::*;
#(
  parameter int ENTRIES        = 64,
  parameter int SLOTS_PER_WORD = 4,
  parameter int MAX_BYTE_OFF   = 62,
  parameter int RESET_BYTE_OFF = 12,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int WORDS  = ENTRIES / SLOTS_PER_WORD,
  localparam int WORD_W = SLOTS_PER_WORD * SLOT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_entry,
  input  logic [7:0]       cfg_first,
  input  logic [7:0]       cfg_second,
  input  logic [15:0]      cfg_mask,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [7:0]       in_data,
  input  logic [IDX_W-1:0] in_sel,
  output logic [15:0]      fld_data,
  output logic             fld_valid,
  output logic             fld_match,
  output logic             short_pkt,
  output logic             cfg_err
);

  logic                    cfg_accept;
  logic                    cfg_reject;
  flx_slot_t               cfg_slot;
  flx_slot_t               sel_slot;
  logic [WORDS*WORD_W-1:0] cfg_words;

  flx_cfg_check #(
    .MAX_BYTE_OFF (MAX_BYTE_OFF)
  ) u_check (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (cfg_we),
    .first_b  (cfg_first),
    .second_b (cfg_second),
    .mask     (cfg_mask),
    .accept   (cfg_accept),
    .reject   (cfg_reject),
    .slot     (cfg_slot),
    .err_q    (cfg_err)
  );

  flx_slot_store #(
    .ENTRIES        (ENTRIES),
    .SLOTS_PER_WORD (SLOTS_PER_WORD),
    .RESET_BYTE_OFF (RESET_BYTE_OFF)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_accept),
    .wr_idx     (cfg_entry),
    .wr_slot    (cfg_slot),
    .rd_idx     (in_sel),
    .rd_slot    (sel_slot),
    .words_flat (cfg_words)
  );

  flx_field_capture u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .in_data   (in_data),
    .sop_slot  (sel_slot),
    .fld_data  (fld_data),
    .fld_valid (fld_valid),
    .fld_match (fld_match),
    .short_pkt (short_pkt)
  );

  // R9: a refused request leaves every configuration word untouched
  assert_reject_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reject |=> $stable(cfg_words));

  // R4: configuration words change only on an accepted request
  assert_store_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_accept |=> $stable(cfg_words));

endmodule

// File: tb/flx_field_extract_test.sv
`timescale 1ns/1ps
module flx_field_extract_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [5:0]  cfg_entry;
  logic [7:0]  cfg_first;
  logic [7:0]  cfg_second;
  logic [15:0] cfg_mask;
  logic        in_valid;
  logic        in_sop;
  logic        in_eop;
  logic [7:0]  in_data;
  logic [5:0]  in_sel;
  logic [15:0] fld_data;
  logic        fld_valid;
  logic        fld_match;
  logic        short_pkt;
  logic        cfg_err;

  int errors = 0;
  int checks = 0;

  int m_woff [64];
  int m_dis  [64];
  int m_err;
  logic [7:0] pb [128];

  always #2.5 clk = ~clk;

  flx_field_extract uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_entry(cfg_entry),
    .cfg_first(cfg_first), .cfg_second(cfg_second), .cfg_mask(cfg_mask),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
    .in_sel(in_sel), .fld_data(fld_data), .fld_valid(fld_valid),
    .fld_match(fld_match), .short_pkt(short_pkt), .cfg_err(cfg_err)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int rule_pass(input int a, input int b, input int m);
    if ((a % 2) != 0) return 0;
    if (b - a != 1) return 0;
    if (a > 62) return 0;
    if (m != 0 && m != 65535) return 0;
    return 1;
  endfunction

  task automatic model_write(input int e, input int a, input int b, input int m);
    if (rule_pass(a, b, m) != 0) begin
      m_woff[e] = a / 2;
      m_dis[e]  = (m == 65535) ? 0 : 1;
    end else begin
      m_err = 1;
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++) begin
      m_woff[i] = 6;
      m_dis[i]  = 1;
    end
    m_err = 0;
  endtask

  // Starts and ends just after a falling edge.
  task automatic cfg_write(input int e, input int a, input int b, input int m,
                           input string req);
    cfg_we     = 1'b1;
    cfg_entry  = 6'(e);
    cfg_first  = 8'(a);
    cfg_second = 8'(b);
    cfg_mask   = 16'(m);
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(e, a, b, m);
    chk(cfg_err == 1'(m_err), req, "cfg_err", 32'(cfg_err), 32'(m_err));
  endtask

  // Sends one packet; optional mid-packet config write at beat mid_k.
  task automatic send_pkt(input int sel, input int len, input int gap_pct,
                          input int mid_k, input int me, input int ma,
                          input int mb, input int mm, input string req);
    int w;
    int exp_hit;
    int exp_k;
    int exp_match;
    int nval;
    int nshort;
    int hit_k;
    logic [15:0] got;
    logic        got_m;
    w         = m_woff[sel];
    exp_hit   = (len >= 2 * w + 2) ? 1 : 0;
    exp_k     = 2 * w + 1;
    exp_match = (m_dis[sel] != 0) ? 0 : 1;
    nval = 0; nshort = 0; hit_k = -1; got = '0; got_m = 1'b0;
    for (int k = 0; k < len; k++) begin
      pb[k] = 8'($urandom);
    end
    for (int k = 0; k < len; k++) begin
      while (k > 0 && int'($urandom % 100) < gap_pct) begin
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
        @(negedge clk);
        if (fld_valid || short_pkt) begin
          chk(1'b0, "R11", "event on idle cycle",
              32'({fld_valid, short_pkt}), 32'd0);
        end
      end
      in_valid = 1'b1;
      in_sop   = (k == 0);
      in_eop   = (k == len - 1);
      in_data  = pb[k];
      in_sel   = (k == 0) ? 6'(sel) : 6'($urandom);
      if (k == mid_k) begin
        cfg_we = 1'b1; cfg_entry = 6'(me); cfg_first = 8'(ma);
        cfg_second = 8'(mb); cfg_mask = 16'(mm);
      end
      @(negedge clk);
      if (k == mid_k) begin
        cfg_we = 1'b0;
        model_write(me, ma, mb, mm);
      end
      if (fld_valid) begin
        nval++;
        hit_k = k;
        got   = fld_data;
        got_m = fld_match;
      end
      if (short_pkt) nshort++;
    end
    in_valid = 1'b0;
    in_sop   = 1'b0;
    in_eop   = 1'b0;
    if (exp_hit != 0) begin
      chk(nval == 1 && hit_k == exp_k && nshort == 0, req, "strobe beat",
          32'(hit_k), 32'(exp_k));
      chk(got == {pb[2*w], pb[2*w+1]}, req, "field data",
          32'(got), 32'({pb[2*w], pb[2*w+1]}));
      chk(got_m == 1'(exp_match), req, "fld_match",
          32'(got_m), 32'(exp_match));
    end else begin
      chk(nval == 0 && nshort == 1, req, "short packet",
          32'({nval[15:0], nshort[15:0]}), 32'd1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_entry = '0; cfg_first = '0;
    cfg_second = '0; cfg_mask = '0; in_valid = 1'b0; in_sop = 1'b0;
    in_eop = 1'b0; in_data = '0; in_sel = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk({fld_valid, fld_match, short_pkt, cfg_err} == 4'b0 && fld_data == 16'h0,
        "R1", "outputs after reset",
        32'({fld_data, fld_valid, fld_match, short_pkt, cfg_err}), 32'd0);
    send_pkt(0, 20, 0, -1, 0, 0, 0, 0, "R1");
    send_pkt(63, 13, 0, -1, 0, 0, 0, 0, "R1");

    // R2 R8: offset 0, match enabled
    cfg_write(5, 0, 1, 16'hFFFF, "R8");
    send_pkt(5, 2, 0, -1, 0, 0, 0, 0, "R2");
    // R7: top position, same configuration word as entry 5 (R4)
    cfg_write(6, 62, 63, 0, "R7");
    send_pkt(6, 64, 0, -1, 0, 0, 0, 0, "R7");
    send_pkt(6, 63, 0, -1, 0, 0, 0, 0, "R10");
    send_pkt(5, 9, 0, -1, 0, 0, 0, 0, "R4");
    send_pkt(4, 30, 0, -1, 0, 0, 0, 0, "R4");
    // R10: single-beat packet
    send_pkt(5, 1, 0, -1, 0, 0, 0, 0, "R10");

    // Refused requests on entry 5; its setting must survive
    cfg_write(5, 3, 4, 16'hFFFF, "R5");
    send_pkt(5, 10, 0, -1, 0, 0, 0, 0, "R5");
    cfg_write(5, 4, 6, 16'hFFFF, "R6");
    send_pkt(5, 10, 0, -1, 0, 0, 0, 0, "R6");
    cfg_write(5, 64, 65, 16'hFFFF, "R7");
    send_pkt(5, 10, 0, -1, 0, 0, 0, 0, "R7");
    cfg_write(5, 8, 9, 16'h00FF, "R8");
    send_pkt(5, 10, 0, -1, 0, 0, 0, 0, "R9");
    cfg_write(7, 8, 9, 16'hFFFF, "R9");
    send_pkt(7, 12, 0, -1, 0, 0, 0, 0, "R8");

    // R11: idle gaps inside packets
    send_pkt(7, 25, 40, -1, 0, 0, 0, 0, "R11");
    send_pkt(6, 70, 30, -1, 0, 0, 0, 0, "R11");

    // R12: rewrite the entry in use at beat 2
    send_pkt(7, 20, 0, 2, 7, 0, 1, 0, "R12");
    send_pkt(7, 20, 0, -1, 0, 0, 0, 0, "R12");

    // Random traffic
    for (int n = 0; n < 400; n++) begin
      if ($urandom % 3 == 0) begin
        int a;
        int b;
        int m;
        int r;
        a = int'($urandom % 72);
        if ($urandom % 4 != 0) a = a & ~1;
        b = ($urandom % 5 == 0) ? a + 2 : a + 1;
        r = int'($urandom % 6);
        m = (r < 3) ? 65535 : (r < 5) ? 0 : int'($urandom % 65536);
        cfg_write(int'($urandom % 64), a, b, m, "R9");
      end
      send_pkt(int'($urandom % 64), 1 + int'($urandom % 80),
               ($urandom % 2 == 0) ? 0 : 20, -1, 0, 0, 0, 0, "R2");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule